// File: doc/BRIEF.md
# Two-Stage Cascaded Clocked Delay Controller

This block delays a single-bit clocked signal by a programmable number of clock cycles. It uses two identical tapped delay stages in series. An 11-bit select bus drives it. The low ten bits set the tap of the first stage. The top bit is an extension bit that is held beside that code. The second stage is never programmed directly: its code register is tied to zero, and its tap is chosen only by two override inputs. The first stage's held extension bit drives those overrides. When the bit is clear, the second stage is forced to its shortest tap. When the bit is set, it is forced to its longest tap, which adds one full span of 1024 cycles. One extra select line therefore doubles the programmable range. The cost is that the fixed latency of the two stages adds up.

A single load control serves both stages. While it is low, the select bus is captured on every clock, so the delay follows the bus one cycle later. While it is high, the captured selection is frozen. An output enable gates the result, and the output stays low while the enable is low. Reset is asserted asynchronously and released through a two-flop synchronizer.

Top module: `cascade_delay_pair`

## Requirements
- R1: While reset is active, and afterwards until the first capture, the captured code and extension bit are zero and `dout` is low. Values of `din` that are presented during reset never reach `dout`.
- R2: With the held extension bit (`addr[10]`) at 0, the second stage adds 0 cycles. A `din` sample appears on `dout` after the L-th rising edge, where the sampling edge counts as the first and L = 2*BASE_LAT + `addr[9:0]`.
- R3: With the held extension bit at 1, the second stage adds exactly 1024 cycles, so L = 2*BASE_LAT + 1024 + `addr[9:0]`.
- R4: While `load_en` is low, `addr` is captured on every rising edge. The new delay applies to `dout` right after that edge.
- R5: While `load_en` is high, changes on `addr` have no effect on the delay.
- R6: The ten-bit code and the extension bit are captured on the same edge. A single capture that moves from 1023 to 1024 therefore gives a total step of exactly one cycle.
- R7: When `out_en` is low, `dout` is low. When `out_en` is high, `dout` shows the delayed signal, and the delay line keeps running in both cases.
- R8: The minimum latency, with `addr` = 0, is 2*BASE_LAT cycles, because the base latencies of both stages add.
- R9: The maximum latency, with `addr` = 2047, is 2*BASE_LAT + 2047 cycles.
- R10: At a fixed setting, any bit stream (pulse widths and gaps) is reproduced on `dout` unchanged, with only the shift in time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | 1 | Signal to be delayed |
| addr | input | CODE_W+1 | Bits [9:0] set the first-stage tap code; bit [10] is the extension bit that selects the second stage's longest or shortest tap |
| load_en | input | 1 | Low: capture `addr` on every edge; high: hold the captured value |
| out_en | input | 1 | High passes the delayed signal; low forces `dout` low |
| dout | output | 1 | Delayed signal |

## Verification
Single pulses are sent at the select values 0, 37, 1023, 1029 and 2047. Those placed at the ends of each half of the range separate an error in the base latency from an error in the tap offset or in the second stage's override. A run with `load_en` high and `addr` scrambled on every cycle shows that a held selection ignores the bus. A transparent run with a random stream shows the capture timing. Moving the selection from 1023 to 1024 while a pulse is in flight exposes a code and an extension bit that do not update together. Random streams with a random output enable test pulse-width fidelity and the output gating.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  // Override pair presented to a stage's tap selector.
  typedef struct packed {
    logic force_min;
    logic force_max;
  } pdc_ovr_t;
endpackage

// File: rtl/pdc_hold_reg.sv
module pdc_hold_reg #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         cap_en;

  always_comb begin
    cap_en = ~load_en;
    q_d    = cap_en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/pdc_tap_sel.sv
module pdc_tap_sel
  import pdc_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic [CODE_W-1:0] code,
  input  pdc_ovr_t          ovr,
  output logic [CODE_W:0]   tap
);
  localparam logic [CODE_W:0] TAP_MAX = (CODE_W+1)'(1) << CODE_W;

  // force_min outranks force_max; both outrank the code.
  always_comb begin
    if (ovr.force_min)      tap = '0;
    else if (ovr.force_max) tap = TAP_MAX;
    else                    tap = {1'b0, code};
  end
endmodule

// File: rtl/pdc_tap_line.sv
module pdc_tap_line #(
  parameter int CODE_W   = 10,
  parameter int BASE_LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  input  logic [CODE_W:0] tap,
  output logic            dout
);
  localparam int DEPTH = BASE_LAT + (1 << CODE_W);
  localparam int IW    = $clog2(DEPTH);

  logic [DEPTH-1:0] sr_q;
  logic [DEPTH-1:0] sr_d;
  logic [IW-1:0]    idx;

  always_comb begin
    sr_d = {sr_q[DEPTH-2:0], din};
    idx  = IW'(BASE_LAT - 1) + IW'(tap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign dout = sr_q[idx];
endmodule

// File: rtl/cascade_delay_pair.sv
module cascade_delay_pair
  import pdc_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int BASE_LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            din,
  input  logic [CODE_W:0] addr,
  input  logic            load_en,
  input  logic            out_en,
  output logic            dout
);
  localparam int NSTG = 2;

  // Reset: asynchronous assert, synchronous release.
  logic rst_meta_q, rst_int_n;
  logic rst_meta_d, rst_int_d;
  always_comb begin
    rst_meta_d = 1'b1;
    rst_int_d  = rst_meta_q;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= rst_meta_d;
      rst_int_n  <= rst_int_d;
    end
  end

  // Held selections: stage 0 takes the bus, stage 1's code is tied low.
  logic [CODE_W:0]   sel_q;
  logic [CODE_W-1:0] s1_code, s2_code;
  logic              s1_casc;
  logic [CODE_W:0]   s1_tap, s2_tap;
  logic              s1_out, s2_out;

  pdc_hold_reg #(.W(CODE_W + 1)) u_sel1 (
    .clk(clk), .rst_n(rst_int_n), .load_en(load_en), .d(addr), .q(sel_q)
  );
  pdc_hold_reg #(.W(CODE_W)) u_sel2 (
    .clk(clk), .rst_n(rst_int_n), .load_en(load_en), .d('0), .q(s2_code)
  );

  assign s1_code = sel_q[CODE_W-1:0];
  assign s1_casc = sel_q[CODE_W];

  // Override wiring and per-stage data path, built per stage.
  pdc_ovr_t          ovr   [NSTG];
  logic [CODE_W-1:0] code  [NSTG];
  logic [CODE_W:0]   tap   [NSTG];
  logic              s_in  [NSTG];
  logic              s_out [NSTG];

  always_comb begin
    ovr[0]  = '{force_min: 1'b0, force_max: 1'b0};
    ovr[1]  = '{force_min: ~s1_casc, force_max: s1_casc};
    code[0] = s1_code;
    code[1] = s2_code;
    s_in[0] = din;
    s_in[1] = s_out[0];
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    pdc_tap_sel #(.CODE_W(CODE_W)) u_tsel (
      .code(code[g]), .ovr(ovr[g]), .tap(tap[g])
    );
    pdc_tap_line #(.CODE_W(CODE_W), .BASE_LAT(BASE_LAT)) u_line (
      .clk(clk), .rst_n(rst_int_n), .din(s_in[g]), .tap(tap[g]), .dout(s_out[g])
    );
  end

  assign s1_tap = tap[0];
  assign s2_tap = tap[1];
  assign s1_out = s_out[0];
  assign s2_out = s_out[1];

  assign dout = out_en & s2_out;
endmodule

// File: rtl/cdp_checker.sv
module cdp_checker #(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_int_n,
  input logic              load_en,
  input logic [CODE_W:0]   addr,
  input logic [CODE_W-1:0] code1,
  input logic              casc,
  input logic [CODE_W:0]   tap1,
  input logic [CODE_W:0]   tap2
);
  localparam logic [CODE_W:0] SPAN = (CODE_W+1)'(1) << CODE_W;

  // R1: selection is clear whenever reset is held.
  always @(posedge clk) begin
    if (!rst_n) p_rst_r1: assert (code1 == '0 && !casc);
  end

  // R4: a transparent edge captures the bus code.
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rst_int_n && !load_en) |=> (code1 == $past(addr[CODE_W-1:0])));

  // R6: the extension bit is captured on that same edge.
  p_casc_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rst_int_n && !load_en) |=> (casc == $past(addr[CODE_W])));

  // R5: a held selection does not move.
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_en |=> ($stable(code1) && $stable(casc)));

  // R2: extension clear puts stage two at its shortest tap.
  p_min_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !casc |-> (tap2 == '0));

  // R3: extension set puts stage two at one full span.
  p_max_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    casc |-> (tap2 == SPAN));

  // R2: stage one's tap is never overridden.
  p_s1_code_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    tap1 == {1'b0, code1});
endmodule

bind cascade_delay_pair cdp_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n), .load_en(load_en),
  .addr(addr), .code1(s1_code), .casc(s1_casc), .tap1(s1_tap), .tap2(s2_tap)
);

// File: tb/sim_cascade_delay_pair.sv
`timescale 1ns/1ps
module sim_cascade_delay_pair;
  localparam int CW  = 10;
  localparam int BL  = 2;
  localparam int HSZ = 65536;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          din;
  logic [CW:0]   addr;
  logic          load_en;
  logic          out_en;
  logic          dout;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic in_h [HSZ];
  logic s1_h [HSZ];
  int   n      = 0;
  int   code_m = 0;
  int   casc_m = 0;

  cascade_delay_pair #(.CODE_W(CW), .BASE_LAT(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .addr(addr),
    .load_en(load_en), .out_en(out_en), .dout(dout)
  );

  always #2.5 clk = ~clk;

  function automatic logic get_in(int i);
    return (i < 0) ? 1'b0 : in_h[i];
  endfunction
  function automatic logic get_s1(int i);
    return (i < 0) ? 1'b0 : s1_h[i];
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: dout=%b expected=%b", tag, n, act, exp);
    end
  endtask

  // One clock: drive, let the edge pass, update the model, compare at negedge.
  task automatic step(string tag, logic d, logic [CW:0] a, logic le, logic oe);
    int   t1, t2;
    logic s1v, s2v, e;
    din = d; addr = a; load_en = le; out_en = oe;
    @(posedge clk);
    if (!le) begin
      code_m = int'(a[CW-1:0]);
      casc_m = int'(a[CW]);
    end
    in_h[n] = d;
    t1  = code_m;
    t2  = (casc_m != 0) ? (1 << CW) : 0;
    s1v = get_in(n - BL + 1 - t1);
    s1_h[n] = s1v;
    s2v = get_s1(n - BL - t2);
    e   = oe ? s2v : 1'b0;
    @(negedge clk);
    check(tag, dout, e);
    n++;
  endtask

  task automatic load(string tag, logic [CW:0] a);
    step(tag, 1'b0, a, 1'b0, 1'b1);
  endtask

  task automatic pulse_run(string tag, int width, int tail);
    for (int i = 0; i < width; i++) step(tag, 1'b1, '0, 1'b1, 1'b1);
    for (int i = 0; i < tail; i++)  step(tag, 1'b0, '0, 1'b1, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; din = 1'b1; addr = '1; load_en = 1'b0; out_en = 1'b1;
    // R1: outputs quiet while reset is held, even with din high
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1", dout, 1'b0);
    end
    din = 1'b0; load_en = 1'b1; addr = '0;
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1", dout, 1'b0);
    end

    // R8: minimum latency at select 0
    load("R8", 11'd0);
    pulse_run("R8", 1, 20);

    // R2: mid code, two pulse widths
    load("R2", 11'd37);
    pulse_run("R2", 3, 5);
    pulse_run("R2", 1, 80);

    // R2: top of the lower half
    load("R2", 11'd1023);
    pulse_run("R2", 2, 1040);

    // R3: extension set with a small code
    load("R3", 11'h405);
    pulse_run("R3", 1, 1050);

    // R9: maximum latency
    load("R9", 11'h7FF);
    pulse_run("R9", 1, 2070);

    // R5: bus scrambled every cycle while held
    for (int i = 0; i < 2200; i++) begin
      logic [CW:0] ra;
      ra = CW'($urandom);
      ra[CW] = $urandom_range(0, 1) != 0;
      step("R5", (i % 700) < 2, ra, 1'b1, 1'b1);
    end

    // R4: transparent capture with a random stream
    for (int i = 0; i < 300; i++) begin
      logic [CW:0] ra;
      ra = (CW+1)'($urandom_range(0, 40));
      if (i % 50 > 40) ra[CW] = 1'b1;
      step("R4", $urandom_range(0, 1) != 0, ra, 1'b0, 1'b1);
    end

    // R6: one capture moves 1023 -> 1024 while a pulse is in flight
    load("R6", 11'd1023);
    pulse_run("R6", 2, 30);
    load("R6", 11'h400);
    pulse_run("R6", 0, 1100);

    // R7: output enable toggling over a random stream
    load("R7", 11'd3);
    for (int i = 0; i < 200; i++)
      step("R7", $urandom_range(0, 1) != 0, '0, 1'b1, $urandom_range(0, 3) != 0);

    // R10: random stream at a fixed setting
    load("R10", 11'd300);
    for (int i = 0; i < 1000; i++)
      step("R10", $urandom_range(0, 2) != 0, '0, 1'b1, 1'b1);
    for (int i = 0; i < 320; i++) step("R10", 1'b0, '0, 1'b1, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", n);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule